// File: doc/BRIEF.md
# Memory Pattern Fill Writer

This block fills a fixed-size region of external memory with a counting test pattern. It is an AXI4 memory-mapped write master: it issues address, write-data and write-response traffic and drives nothing else on the bus. The read channels have only their two master-driven valid/ready outputs, and both are held low. The region is `NUM_WORDS` words of `DATA_W` bits. Word `i` of the region receives the value `i`.

A controller starts a run by raising `start_i` and keeps it high until the block answers with `ready_o`. `done_o` and `ready_o` pulse together once the write response for the final burst has arrived. If `start_i` is still high in that cycle, the block treats it as a new request and fills the region again straight away. The write base comes from `base_addr_i`, which the surrounding design normally ties to a constant. With `USE_OFFSET` cleared, that port is ignored and the region starts at address zero.

Traffic goes out as INCR bursts of at most `MAX_BURST` beats. A burst is shortened wherever it would cross a 4 KB page, and also for the final words of the region. Only one burst is in flight at a time. A non-OKAY write response raises a sticky error flag.

Top module: `mem_fill_writer`

## Requirements
- R1: After reset `idle_o` is 1, and `done_o`, `ready_o`, `err_o`, `m_awvalid`, `m_wvalid`, `m_bready`, `m_arvalid` and `m_rready` are 0. While idle with `start_i` low, no AXI valid is raised.
- R2: Word `i` of the region is written with data value `i`. Every beat has `m_wstrb` all ones, `m_awsize` = 3'b010 (4 bytes) and `m_awburst` = 2'b01 (INCR).
- R3: The byte address of word `i` is `base + 4*i`. `base` is `base_addr_i` with its two low bits cleared when `USE_OFFSET` = 1, and zero when `USE_OFFSET` = 0.
- R4: Each burst has at most 16 beats. `m_awlen` is the beat count minus one, and `m_wlast` is high on exactly the final beat of each burst.
- R5: No burst crosses a 4 KB address boundary.
- R6: Once `m_awvalid` or `m_wvalid` is raised, it stays high until its ready is seen. The address, length, data and last flag stay unchanged until then.
- R7: `done_o` and `ready_o` are high together for exactly one cycle, and only after the response of the last burst has been accepted. If `start_i` is low in that cycle, `idle_o` is 1 in the next cycle.
- R8: If `start_i` is high during the `done_o` cycle, a new run begins at once: `idle_o` stays 0 and the next cycle presents the first burst address.
- R9: A write response other than OKAY (`m_bresp` != 2'b00) sets `err_o`. `err_o` stays set through completion and idle, and is cleared when the next start is accepted.
- R10: A new address is issued only after the previous burst's response has been accepted. A run writes exactly `NUM_WORDS` words and then stops issuing traffic.
- R11: A start is accepted when `start_i` is high in an idle cycle. `idle_o` goes low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run request; hold high until `ready_o` |
| idle_o | output | 1 | Block is idle |
| ready_o | output | 1 | Request consumed, pulses with `done_o` |
| done_o | output | 1 | Run complete, one-cycle pulse |
| err_o | output | 1 | Sticky non-OKAY write response flag |
| base_addr_i | input | ADDR_W | Byte base address of the region |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start byte address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type (INCR) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid, held 0 |
| m_rready | output | 1 | Read data ready, held 0 |

## Verification
The hardest cases to reach are a 4 KB boundary that falls inside the region, and a run that finishes while `start_i` is still high. The first needs base addresses only a few words below a page edge, so that a short first burst appears. The second needs the controller to keep the request raised across the `done_o` cycle. The bench walks a table of base addresses placed 1, 4 and 48 words below a page edge, and models each AXI channel with its own ready/valid gap pattern so that payloads must be held under back-pressure. A non-OKAY response is injected on one chosen burst. Directed runs hold `start_i` through completion and drive a second instance that has the offset disabled.

// File: rtl/mfw_pkg.sv
package mfw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP,
    ST_FIN
  } mfw_state_e;

  localparam int unsigned PAGE_BYTES = 4096;

  // Beats of the next burst: limited by the cap, the words left and the room
  // before the next 4 KB page edge (page_off is the address within the page).
  function automatic int unsigned burst_beats(input logic [11:0] page_off,
                                              input int unsigned remaining,
                                              input int unsigned cap,
                                              input int unsigned shift);
    int unsigned room;
    int unsigned n;
    room = (PAGE_BYTES - {20'd0, page_off}) >> shift;
    n = cap;
    if (remaining < n) n = remaining;
    if (room < n) n = room;
    return n;
  endfunction

  // Byte address of a word index relative to a base.
  function automatic logic [63:0] word_addr(input logic [63:0] base,
                                            input logic [63:0] idx,
                                            input int unsigned shift);
    return base + (idx << shift);
  endfunction

endpackage

// File: rtl/mfw_ctrl.sv
module mfw_ctrl
  import mfw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 256,
  parameter int MAX_BURST = 16,
  parameter int BYTES     = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS + 1),
  localparam int SHIFT    = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              awready_i,
  input  logic              wlast_fire_i,
  input  logic              b_fire_i,
  output logic              awvalid_o,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [7:0]        awlen_o,
  output logic              aw_fire_o,
  output logic [IDX_W-1:0]  first_idx_o,
  output logic [8:0]        beats_o,
  output logic              bready_o,
  output logic              idle_o,
  output logic              fin_o,
  output logic              start_accept_o
);

  mfw_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [8:0]        cur_beats;
  logic              last_burst;
  logic [ADDR_W-1:0] base_aligned;

  assign base_aligned = base_i & ~ADDR_W'(BYTES - 1);

  always_comb begin
    logic [63:0] wide;
    wide      = word_addr(64'(base_q), 64'(idx_q), SHIFT);
    cur_addr  = wide[ADDR_W-1:0];
    cur_beats = 9'(burst_beats(cur_addr[11:0],
                               NUM_WORDS - int'(idx_q),
                               MAX_BURST, SHIFT));
  end

  assign last_burst     = (int'(idx_q) + int'(cur_beats)) == NUM_WORDS;
  assign idle_o         = (state_q == ST_IDLE);
  assign fin_o          = (state_q == ST_FIN);
  assign start_accept_o = (idle_o || fin_o) && start_i;
  assign awvalid_o      = (state_q == ST_ADDR);
  assign awaddr_o       = cur_addr;
  assign awlen_o        = 8'(cur_beats - 9'd1);
  assign aw_fire_o      = awvalid_o && awready_i;
  assign first_idx_o    = idx_q;
  assign beats_o        = cur_beats;
  assign bready_o       = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_FIN: begin
          if (start_i) begin
            state_q <= ST_ADDR;
            idx_q   <= '0;
            base_q  <= base_aligned;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: if (awready_i) state_q <= ST_DATA;
        ST_DATA: if (wlast_fire_i) state_q <= ST_RESP;
        ST_RESP: begin
          if (b_fire_i) begin
            idx_q   <= idx_q + IDX_W'(cur_beats);
            state_q <= last_burst ? ST_FIN : ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !awvalid_o && !bready_o);  // R1
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o) && $stable(awlen_o));  // R6
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid_o |-> (int'(awlen_o) < MAX_BURST));  // R4
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid_o |-> ({2'b00, awaddr_o[11:0]} + ((14'(awlen_o) + 14'd1) << SHIFT)) <= 14'h1000);  // R5
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);  // R7
  AST_FIN_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_o) |-> $past(b_fire_i));  // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o && start_i |=> awvalid_o && (awaddr_o == $past(base_aligned)));  // R8

endmodule

// File: rtl/mfw_wbeat.sv
module mfw_wbeat #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 256,
  localparam int IDX_W    = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  first_idx_i,
  input  logic [8:0]        beats_i,
  input  logic              wready_i,
  output logic              wvalid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wlast_o,
  output logic              last_fire_o
);

  logic             active_q;
  logic [8:0]       left_q;
  logic [IDX_W-1:0] word_q;
  logic             beat_fire;

  assign wvalid_o    = active_q;
  assign wdata_o     = DATA_W'(word_q);
  assign wlast_o     = active_q && (left_q == 9'd1);
  assign beat_fire   = active_q && wready_i;
  assign last_fire_o = beat_fire && wlast_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      word_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      left_q   <= beats_i;
      word_q   <= first_idx_i;
    end else if (beat_fire) begin
      left_q <= left_q - 9'd1;
      word_q <= word_q + IDX_W'(1);
      if (left_q == 9'd1) active_q <= 1'b0;
    end
  end

  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid_o && !wready_i |=> wvalid_o && $stable(wdata_o) && $stable(wlast_o));  // R6
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !wlast_o |=> wvalid_o && (wdata_o == $past(wdata_o) + DATA_W'(1)));  // R2
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_q);  // R10

endmodule

// File: rtl/mfw_bresp.sv
module mfw_bresp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bvalid_i,
  input  logic       bready_i,
  input  logic [1:0] bresp_i,
  input  logic       clear_i,
  output logic       b_fire_o,
  output logic       err_o
);

  logic err_q;

  assign b_fire_o = bvalid_i && bready_i;
  assign err_o    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (b_fire_o && (bresp_i != 2'b00)) begin
      err_q <= 1'b1;
    end else if (clear_i) begin
      err_q <= 1'b0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clear_i |=> err_q);  // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire_o && (bresp_i != 2'b00) |=> err_q);  // R9

endmodule

// File: rtl/mem_fill_writer.sv
module mem_fill_writer #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_WORDS  = 256,
  parameter int MAX_BURST  = 16,
  parameter bit USE_OFFSET = 1'b1,
  localparam int BYTES     = DATA_W / 8,
  localparam int IDX_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                idle_o,
  output logic                ready_o,
  output logic                done_o,
  output logic                err_o,
  input  logic [ADDR_W-1:0]   base_addr_i,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [BYTES-1:0]    m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                m_arvalid,
  output logic                m_rready
);

  logic [ADDR_W-1:0] base_eff;
  logic              aw_fire;
  logic [IDX_W-1:0]  first_idx;
  logic [8:0]        beats;
  logic              wlast_fire;
  logic              b_fire;
  logic              fin;
  logic              start_accept;

  generate
    if (USE_OFFSET) begin : g_offset
      assign base_eff = base_addr_i;
    end else begin : g_zero
      logic unused_base;
      assign unused_base = ^base_addr_i;
      assign base_eff    = '0;
    end
  endgenerate

  mfw_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .MAX_BURST(MAX_BURST), .BYTES(BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_eff),
    .awready_i(m_awready), .wlast_fire_i(wlast_fire), .b_fire_i(b_fire),
    .awvalid_o(m_awvalid), .awaddr_o(m_awaddr), .awlen_o(m_awlen),
    .aw_fire_o(aw_fire), .first_idx_o(first_idx), .beats_o(beats),
    .bready_o(m_bready), .idle_o(idle_o), .fin_o(fin),
    .start_accept_o(start_accept)
  );

  mfw_wbeat #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_wbeat (
    .clk(clk), .rst_n(rst_n), .load_i(aw_fire), .first_idx_i(first_idx),
    .beats_i(beats), .wready_i(m_wready), .wvalid_o(m_wvalid),
    .wdata_o(m_wdata), .wlast_o(m_wlast), .last_fire_o(wlast_fire)
  );

  mfw_bresp u_bresp (
    .clk(clk), .rst_n(rst_n), .bvalid_i(m_bvalid), .bready_i(m_bready),
    .bresp_i(m_bresp), .clear_i(start_accept), .b_fire_o(b_fire), .err_o(err_o)
  );

  assign done_o    = fin;
  assign ready_o   = fin;
  assign m_awsize  = 3'($clog2(BYTES));
  assign m_awburst = 2'b01;
  assign m_wstrb   = '1;
  assign m_arvalid = 1'b0;
  assign m_rready  = 1'b0;

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o && !m_awvalid && !m_wvalid);  // R7
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> !m_awvalid && !m_bready);  // R10

endmodule

// File: tb/mem_fill_writer_tb.sv
module mem_fill_writer_tb_top;

  localparam int NW = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [1:0]  bresp = 2'b00;
  logic        idle, rdy, done, err, awvalid, wvalid, wlast, bready, arvalid, rready;
  logic [31:0] awaddr, wdata;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic [3:0]  wstrb;

  always #4 clk = ~clk;

  mem_fill_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .idle_o(idle), .ready_o(rdy),
    .done_o(done), .err_o(err), .base_addr_i(base_addr),
    .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awlen(awlen),
    .m_awsize(awsize), .m_awburst(awburst), .m_wvalid(wvalid), .m_wready(wready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_bvalid(bvalid),
    .m_bready(bready), .m_bresp(bresp), .m_arvalid(arvalid), .m_rready(rready)
  );

  // second instance with the offset disabled
  logic        z_start = 1'b0;
  logic        z_idle, z_rdy, z_done, z_err, z_awv, z_wv, z_wl, z_br, z_arv, z_rr;
  logic [31:0] z_awaddr, z_wdata;
  logic [7:0]  z_awlen;
  logic [2:0]  z_awsize;
  logic [1:0]  z_awburst;
  logic [3:0]  z_wstrb;

  mem_fill_writer #(.NUM_WORDS(4), .USE_OFFSET(1'b0)) dut_z0 (
    .clk(clk), .rst_n(rst_n), .start_i(z_start), .idle_o(z_idle), .ready_o(z_rdy),
    .done_o(z_done), .err_o(z_err), .base_addr_i(32'h0000_5000),
    .m_awvalid(z_awv), .m_awready(1'b1), .m_awaddr(z_awaddr), .m_awlen(z_awlen),
    .m_awsize(z_awsize), .m_awburst(z_awburst), .m_wvalid(z_wv), .m_wready(1'b1),
    .m_wdata(z_wdata), .m_wstrb(z_wstrb), .m_wlast(z_wl), .m_bvalid(1'b1),
    .m_bready(z_br), .m_bresp(2'b00), .m_arvalid(z_arv), .m_rready(z_rr)
  );

  // stimulus / expected-result table: base, aw gaps, w/b gaps, error burst, bursts
  localparam logic [31:0] V_BASE [4] = '{32'h0000_1000, 32'h0000_1FF0, 32'h8000_0FFC, 32'h2000_0F40};
  localparam logic [7:0]  V_AWG  [4] = '{8'hFF, 8'hB6, 8'h55, 8'hEF};
  localparam logic [7:0]  V_WG   [4] = '{8'hFF, 8'h6D, 8'hDB, 8'h81};
  localparam int          V_ERRB [4] = '{-1, -1, 5, -1};
  localparam int          V_NBUR [4] = '{16, 17, 17, 16};

  int n_chk = 0, n_bad = 0;

  // slave model state
  logic [31:0] s_base = '0;
  logic [7:0]  s_awg = 8'hFF, s_wg = 8'hFF;
  int s_errb = -1, cyc = 0, b_pend = 0, b_idx = 0, bursts = 0, beats = 0, next_word = 0;
  int cur_beat = 0, cur_len = 0;
  bit in_burst = 0, b_took = 0;
  int v_data = 0, v_addr = 0, v_len = 0, v_cross = 0, v_last = 0, v_order = 0, v_attr = 0, v_hold = 0;
  bit p_aw = 0, p_w = 0;
  logic [31:0] p_awaddr, p_wdata;
  logic [7:0]  p_awlen;
  logic        p_wlast;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_run();
    bursts = 0; beats = 0; b_idx = 0; next_word = 0;
    v_data = 0; v_addr = 0; v_len = 0; v_cross = 0; v_last = 0; v_order = 0; v_attr = 0; v_hold = 0;
  endtask

  initial begin : slave
    forever begin
      @(negedge clk);
      cyc++;
      // R6: payload held while valid waits for ready
      if (p_aw && !(awvalid && awaddr == p_awaddr && awlen == p_awlen)) v_hold++;
      if (p_w && !(wvalid && wdata == p_wdata && wlast == p_wlast)) v_hold++;
      if (b_took) begin b_pend--; b_took = 0; bvalid = 1'b0; end
      if (!bvalid && b_pend > 0 && s_wg[cyc % 8]) begin
        bvalid = 1'b1;
        bresp  = (b_idx == s_errb) ? 2'b10 : 2'b00;
      end
      if (bvalid && bready) begin b_took = 1; b_idx++; end
      awready = s_awg[cyc % 8];
      p_aw = awvalid && !awready; p_awaddr = awaddr; p_awlen = awlen;
      if (awvalid && awready) begin
        if (next_word == NW) next_word = 0;
        if (b_pend != 0 || in_burst) v_order++;
        if (awlen > 8'd15) v_len++;
        if (({20'd0, awaddr[11:0]} + (32'(awlen) + 1) * 4) > 32'h1000) v_cross++;
        if (awaddr != s_base + 32'(next_word) * 4) v_addr++;
        if (awsize != 3'b010 || awburst != 2'b01) v_attr++;
        cur_beat = 0; cur_len = int'(awlen); in_burst = 1; bursts++;
      end
      wready = s_wg[(cyc + 3) % 8];
      p_w = wvalid && !wready; p_wdata = wdata; p_wlast = wlast;
      if (wvalid && wready) begin
        if (!in_burst) v_order++;
        if (wdata != 32'(next_word)) v_data++;
        if (wstrb != 4'hF) v_attr++;
        if (wlast != (cur_beat == cur_len)) v_last++;
        next_word++; cur_beat++; beats++;
        if (wlast) begin in_burst = 0; b_pend++; end
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_vec(input int v);
    @(negedge clk);
    s_base = V_BASE[v]; s_awg = V_AWG[v]; s_wg = V_WG[v]; s_errb = V_ERRB[v];
    clr_run();
    base_addr = V_BASE[v];
    start = 1'b1;
    @(negedge clk);
    chk(idle == 1'b0, "R11 idle low after accept", idle, 0);
    chk(err == 1'b0, "R9 err cleared on accept", err, 0);
    wait_done();
    chk(rdy == 1'b1, "R7 ready with done", rdy, 1);
    chk(b_idx == V_NBUR[v], "R7 done after last response", b_idx, V_NBUR[v]);
    chk(bursts == V_NBUR[v], "R5 burst count at page edges", bursts, V_NBUR[v]);
    chk(beats == NW, "R10 word count", beats, NW);
    chk(v_data == 0, "R2 data pattern", v_data, 0);
    chk(v_attr == 0, "R2 strobe/size/burst", v_attr, 0);
    chk(v_addr == 0, "R3 address", v_addr, 0);
    chk(v_len == 0 && v_last == 0, "R4 length and last", v_len + v_last, 0);
    chk(v_cross == 0, "R5 page crossing", v_cross, 0);
    chk(v_hold == 0, "R6 hold under backpressure", v_hold, 0);
    chk(v_order == 0, "R10 one burst in flight", v_order, 0);
    chk(err == (V_ERRB[v] >= 0), "R9 err at done", err, V_ERRB[v] >= 0);
    start = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1 && done == 1'b0, "R7 idle after done", {idle, done}, 2'b10);
    chk(err == (V_ERRB[v] >= 0), "R9 err sticky while idle", err, V_ERRB[v] >= 0);
    repeat (3) @(negedge clk);
    chk(awvalid == 1'b0 && wvalid == 1'b0, "R10 stops after run", {awvalid, wvalid}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && !done && !rdy && !err, "R1 reset status", {idle, done, rdy, err}, 4'b1000);
    chk(!awvalid && !wvalid && !bready && !arvalid && !rready, "R1 reset bus",
        {awvalid, wvalid, bready, arvalid, rready}, 0);
    repeat (4) @(negedge clk);
    chk(idle && !awvalid, "R11 no start stays idle", {idle, awvalid}, 2'b10);

    for (int v = 0; v < 4; v++) run_vec(v);

    // R8: start held through completion restarts at once
    @(negedge clk);
    s_base = 32'h0000_3000; s_awg = 8'hFF; s_wg = 8'hFF; s_errb = -1;
    clr_run();
    base_addr = 32'h0000_3000;
    start = 1'b1;
    wait_done();
    chk(rdy == 1'b1, "R8 ready at first completion", rdy, 1);
    @(negedge clk);
    chk(idle == 1'b0 && awvalid == 1'b1 && awaddr == 32'h0000_3000, "R8 restart",
        {idle, awvalid}, 2'b01);
    start = 1'b0;
    wait_done();
    chk(bursts == 32 && beats == 2 * NW, "R8 two full runs", beats, 2 * NW);
    chk(v_data == 0 && v_addr == 0, "R8 second run pattern", v_data + v_addr, 0);
    @(negedge clk);
    chk(idle == 1'b1, "R7 idle after second run", idle, 1);

    // R3: offset disabled, base port ignored
    z_start = 1'b1;
    do @(negedge clk); while (!z_awv);
    chk(z_awaddr == 32'h0 && z_awlen == 8'd3, "R3 zero base", z_awaddr, 0);
    z_start = 1'b0;
    do @(negedge clk); while (!z_done);
    chk(z_err == 1'b0, "R3 zero-base run completes", z_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule